// File: doc/BRIEF.md
# DRAM Initialization and Refresh Sequencer

This block drives the active-low row strobe, column strobe and write enable of an asynchronous page-mode DRAM through start-up, periodic refresh and self refresh. After reset it holds every strobe inactive for the power-up pause. It then runs a burst of column-before-row refresh cycles and raises `ready_o`. From then on it starts one refresh per refresh interval on its own. The refresh point moves later while a normal access is in progress, but it never passes the interval limit.

A request on `self_ref_req_i` makes the block run a refresh cycle and then a held column-before-row cycle with both strobes low. That hold is the self-refresh state, and it lasts while the request stays high. On exit the block picks one of two precharge lengths from the length of the hold, then runs another refresh cycle at once. `busy_o` tells the access path to keep off the strobes. It rises one clock before any refresh that starts from idle. All timing is given in nanoseconds as parameters and converted to clock counts using the `CLK_NS` parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset all three strobes are high, `ready_o` is low and `busy_o` is high. The first column-strobe fall comes exactly PAUSE_CYC = ceil(PAUSE_NS/CLK_NS) clocks after reset is released.
- R2: `ready_o` rises only after exactly INIT_CYCLES refresh cycles (8 by default) and then never falls. A self-refresh request seen before that point has no effect: no hold is made during initialization.
- R3: In every refresh cycle the column strobe falls while the row strobe is high, and stays low for exactly CSR_CYC clocks before the row strobe falls. In a normal refresh the row strobe stays low for exactly RAS_CYC clocks. Both strobes rise in the same clock.
- R4: The write strobe stays high in every clock.
- R5: Two column-strobe falls are never more than REF_CYC clocks apart, counting from the end of any self-refresh hold. This gives at least 4096 refreshes per 64 ms when REF_NS is 15600.
- R6: With no access in progress, each refresh starts exactly REF_CYC - LEAD_CYC + 2 clocks after the previous one.
- R7: Once ready, `busy_o` is high in the clock before every column-strobe fall. A rise of `busy_o` is followed by a column-strobe fall in the next clock.
- R8: While `access_busy_i` stays high, a due refresh is deferred. It starts exactly REF_CYC clocks after the previous refresh.
- R9: A self-refresh request in idle produces a refresh cycle and then a hold with both strobes low. The hold lasts while the request is high and is at least RAS_CYC clocks long.
- R10: The hold begins with no pause after the refresh that precedes it, so its column-strobe fall is CSR_CYC + RAS_CYC + RP_CYC clocks after that refresh's fall. Another refresh follows within REF_CYC clocks of leaving the hold.
- R11: After a hold of at least SELF_CYC clocks of row strobe low, the strobes stay high for exactly RPS_CYC clocks before the next cycle. After a shorter hold they stay high for exactly RP_CYC clocks. After a normal refresh they stay high for at least RP_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low start-up reset |
| self_ref_req_i | input | 1 | Request to enter and stay in self refresh |
| access_busy_i | input | 1 | A normal access owns the strobes; defers refresh |
| ready_o | output | 1 | Initialization finished |
| busy_o | output | 1 | Sequencer owns or is about to own the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low, held high |

## Verification
The bench builds the block with CLK_NS = 4, and the nanosecond values scaled down so that the pause is 500 clocks and the refresh limit is 400 clocks. The lead window is 50 clocks, the self-refresh threshold 200 clocks and the long precharge 10 clocks. With these values the full pause, all eight initialization cycles, several refresh intervals with and without deferral, and self-refresh holds on both sides of the threshold fit in a few thousand clocks. The exact pause length, the refresh spacing and the precharge choice are therefore checked at their boundaries, not just scaled by proportion.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_ARM,
    ST_CSR,
    ST_RAS,
    ST_PRE,
    ST_IDLE,
    ST_SELF
  } seq_state_e;

  typedef enum logic [2:0] {
    K_INIT,
    K_REG,
    K_SR_PRE,
    K_SR_HOLD,
    K_SR_POST
  } cyc_kind_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int REF_CYC  = 400,
  parameter int LEAD_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic due_o,
  output logic force_o
);

  localparam int CW       = $clog2(REF_CYC + 1);
  localparam int DUE_AT   = REF_CYC - LEAD_CYC;
  localparam int FORCE_AT = REF_CYC - 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (start_i || hold_i)    cnt_q <= '0;
    else if (cnt_q != CW'(REF_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign due_o   = (cnt_q >= CW'(DUE_AT));
  assign force_o = (cnt_q >= CW'(FORCE_AT));

  // a start must land inside the interval limit
  p_start_in_time_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_q < CW'(REF_CYC)));

endmodule

// File: rtl/dwell_meter.sv
module dwell_meter #(
  parameter int MIN_CYC  = 5,
  parameter int LONG_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic min_o,
  output logic long_o
);

  localparam int TOP = (MIN_CYC > LONG_CYC) ? MIN_CYC : LONG_CYC;
  localparam int CW  = $clog2(TOP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!active_i)         cnt_q <= '0;
    else if (cnt_q != CW'(TOP)) cnt_q <= cnt_q + 1'b1;
  end

  // counts include the current active clock
  assign min_o  = (cnt_q >= CW'(MIN_CYC - 1));
  assign long_o = (cnt_q >= CW'(LONG_CYC - 1));

  p_long_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_o && active_i) |=> (long_o || !active_i));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int PAUSE_NS    = 200000,
  parameter int REF_NS      = 15600,
  parameter int LEAD_NS     = 1000,
  parameter int CSR_NS      = 10,
  parameter int RAS_NS      = 50,
  parameter int RP_NS       = 30,
  parameter int RPS_NS      = 90,
  parameter int SELF_NS     = 100000,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic self_ref_req_i,
  input  logic access_busy_i,
  output logic ready_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);

  localparam int PAUSE_CYC = ns2cyc(PAUSE_NS, CLK_NS);
  localparam int REF_CYC   = ns2cyc(REF_NS, CLK_NS);
  localparam int LEAD_CYC  = ns2cyc(LEAD_NS, CLK_NS);
  localparam int CSR_CYC   = ns2cyc(CSR_NS, CLK_NS);
  localparam int RAS_CYC   = ns2cyc(RAS_NS, CLK_NS);
  localparam int RP_CYC    = ns2cyc(RP_NS, CLK_NS);
  localparam int RPS_CYC   = ns2cyc(RPS_NS, CLK_NS);
  localparam int SELF_CYC  = ns2cyc(SELF_NS, CLK_NS);
  localparam int MAX_DUR   = max2(max2(PAUSE_CYC, RPS_CYC), max2(max2(CSR_CYC, RAS_CYC), RP_CYC));
  localparam int TW        = $clog2(MAX_DUR + 1);
  localparam int IW        = $clog2(INIT_CYCLES + 1);

  seq_state_e      state_q, state_d;
  cyc_kind_e       kind_q, kind_d;
  logic [IW-1:0]   init_q, init_d;
  logic            ready_q, ready_d;
  logic            tmr_load, tmr_done;
  logic [TW-1:0]   tmr_val;
  logic            due, force_ref, start, hold;
  logic            dwell_min, dwell_long;

  seq_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  refresh_pacer #(.REF_CYC(REF_CYC), .LEAD_CYC(LEAD_CYC)) u_pacer (
    .clk_i, .rst_ni, .start_i(start), .hold_i(hold), .due_o(due), .force_o(force_ref)
  );

  dwell_meter #(.MIN_CYC(RAS_CYC), .LONG_CYC(SELF_CYC)) u_dwell (
    .clk_i, .rst_ni, .active_i(state_q == ST_SELF), .min_o(dwell_min), .long_o(dwell_long)
  );

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    init_d   = init_q;
    ready_d  = ready_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PAUSE: if (tmr_done) begin
        state_d  = ST_CSR;
        kind_d   = K_INIT;
        tmr_load = 1'b1;
        tmr_val  = TW'(CSR_CYC - 1);
      end
      ST_ARM: begin
        state_d  = ST_CSR;
        tmr_load = 1'b1;
        tmr_val  = TW'(CSR_CYC - 1);
      end
      ST_CSR: if (tmr_done) begin
        if (kind_q == K_SR_HOLD) begin
          state_d = ST_SELF;
        end else begin
          state_d  = ST_RAS;
          tmr_load = 1'b1;
          tmr_val  = TW'(RAS_CYC - 1);
        end
      end
      ST_RAS: if (tmr_done) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = TW'(RP_CYC - 1);
      end
      ST_PRE: if (tmr_done) begin
        unique case (kind_q)
          K_INIT: begin
            if (init_q == IW'(INIT_CYCLES - 1)) begin
              state_d = ST_IDLE;
              ready_d = 1'b1;
            end else begin
              init_d   = init_q + 1'b1;
              state_d  = ST_CSR;
              tmr_load = 1'b1;
              tmr_val  = TW'(CSR_CYC - 1);
            end
          end
          K_SR_PRE: begin
            if (self_ref_req_i) begin
              state_d  = ST_CSR;
              kind_d   = K_SR_HOLD;
              tmr_load = 1'b1;
              tmr_val  = TW'(CSR_CYC - 1);
            end else begin
              state_d = ST_IDLE;
            end
          end
          K_SR_HOLD: begin
            // refresh right after leaving self refresh
            state_d  = ST_CSR;
            kind_d   = K_SR_POST;
            tmr_load = 1'b1;
            tmr_val  = TW'(CSR_CYC - 1);
          end
          default: state_d = ST_IDLE;
        endcase
      end
      ST_IDLE: begin
        if (due && (!access_busy_i || force_ref)) begin
          state_d = ST_ARM;
          kind_d  = K_REG;
        end else if (self_ref_req_i && !access_busy_i) begin
          state_d = ST_ARM;
          kind_d  = K_SR_PRE;
        end
      end
      ST_SELF: if (!self_ref_req_i && dwell_min) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = dwell_long ? TW'(RPS_CYC - 1) : TW'(RP_CYC - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      kind_q  <= K_INIT;
      init_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      init_q  <= init_d;
      ready_q <= ready_d;
    end
  end

  assign start   = (state_d == ST_CSR) && (state_q != ST_CSR);
  assign hold    = (state_q == ST_PAUSE) || (state_q == ST_SELF);

  assign ready_o = ready_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign ras_n_o = !(state_q inside {ST_RAS, ST_SELF});
  assign cas_n_o = !(state_q inside {ST_CSR, ST_RAS, ST_SELF});
  assign we_n_o  = 1'b1;

  p_cas_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> $rose(cas_n_o));

  p_ready_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_busy_lead_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && ready_o) |-> $past(busy_o));

  p_hold_after_init_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SELF) |-> ready_o);

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;

  localparam int CLK_NS   = 4;
  localparam int PAUSE_NS = 2000;
  localparam int REF_NS   = 1600;
  localparam int LEAD_NS  = 200;
  localparam int CSR_NS   = 8;
  localparam int RAS_NS   = 20;
  localparam int RP_NS    = 12;
  localparam int RPS_NS   = 40;
  localparam int SELF_NS  = 800;
  localparam int NINIT    = 8;

  localparam int PAUSE_CYC = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int REF_CYC   = (REF_NS + CLK_NS - 1) / CLK_NS;
  localparam int LEAD_CYC  = (LEAD_NS + CLK_NS - 1) / CLK_NS;
  localparam int CSR_CYC   = (CSR_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_CYC   = (RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_CYC    = (RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RPS_CYC   = (RPS_NS + CLK_NS - 1) / CLK_NS;
  localparam int SELF_CYC  = (SELF_NS + CLK_NS - 1) / CLK_NS;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic self_ref_req_i = 1'b0;
  logic access_busy_i = 1'b0;
  logic ready_o, busy_o, ras_n_o, cas_n_o, we_n_o;

  always #2 clk_i = ~clk_i;

  dram_refresh_seq #(
    .CLK_NS(CLK_NS), .PAUSE_NS(PAUSE_NS), .REF_NS(REF_NS), .LEAD_NS(LEAD_NS),
    .CSR_NS(CSR_NS), .RAS_NS(RAS_NS), .RP_NS(RP_NS), .RPS_NS(RPS_NS),
    .SELF_NS(SELF_NS), .INIT_CYCLES(NINIT)
  ) dut_i (
    .clk_i, .rst_ni, .self_ref_req_i, .access_busy_i,
    .ready_o, .busy_o, .ras_n_o, .cas_n_o, .we_n_o
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference bookkeeping, sampled on the falling edge
  int  cyc = 0, space = 0, ras_run = 0, cas_run = 0, pre_run = 0;
  int  n_cas = 0, holds = 0, last_space = 0, last_pre = 0, last_hold = 0;
  int  exp_pre = 0;
  bit  pre_exact = 1'b0, busy_pend = 1'b0;
  bit  p_ras = 1'b1, p_cas = 1'b1, p_busy = 1'b1, p_ready = 1'b0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      automatic bit fall_c = p_cas && !cas_n_o;
      automatic bit rise_c = !p_cas && cas_n_o;
      automatic bit fall_r = p_ras && !ras_n_o;
      automatic bit rise_r = !p_ras && ras_n_o;
      cyc++;
      space++;
      chk(we_n_o == 1'b1, "R4", int'(we_n_o), 1);
      if (!ras_n_o) begin
        ras_run = fall_r ? 1 : ras_run + 1;
        if (ras_run > RAS_CYC) space = 0;
      end
      if (!cas_n_o && ras_n_o) cas_run = fall_c ? 1 : cas_run + 1;
      if (ras_n_o && cas_n_o) pre_run++;
      if (busy_pend) begin
        chk(!cas_n_o, "R7", int'(cas_n_o), 0);
        busy_pend = 1'b0;
      end
      if (ready_o && !p_busy && busy_o) busy_pend = 1'b1;
      if (fall_r) chk(cas_run == CSR_CYC, "R3", cas_run, CSR_CYC);
      if (rise_r) begin
        chk(rise_c, "R3", int'(rise_c), 1);
        if (ras_run == RAS_CYC) begin
          pre_exact = 1'b0;
        end else if (ras_run > RAS_CYC) begin
          holds++;
          last_hold = ras_run;
          pre_exact = 1'b1;
          exp_pre = (ras_run >= SELF_CYC) ? RPS_CYC : RP_CYC;
          chk(p_ready, "R2", int'(p_ready), 1);
        end else begin
          chk(1'b0, "R3", ras_run, RAS_CYC);
        end
        pre_run = 1;
      end
      if (fall_c) begin
        chk(ras_n_o, "R3", int'(ras_n_o), 1);
        if (n_cas == 0) begin
          chk(cyc == PAUSE_CYC, "R1", cyc, PAUSE_CYC);
        end else begin
          chk(space <= REF_CYC, "R5", space, REF_CYC);
          if (pre_exact) chk(pre_run == exp_pre, "R11", pre_run, exp_pre);
          else           chk(pre_run >= RP_CYC, "R11", pre_run, RP_CYC);
        end
        if (ready_o) chk(p_busy, "R7", int'(p_busy), 1);
        last_pre   = pre_run;
        pre_exact  = 1'b0;
        last_space = space;
        space      = 0;
        pre_run    = 0;
        n_cas++;
      end
      if (!p_ready && ready_o) begin
        chk(n_cas == NINIT, "R2", n_cas, NINIT);
        chk(holds == 0, "R2", holds, 0);
      end
      if (p_ready && !ready_o) chk(1'b0, "R2", 0, 1);
    end
    p_ras   = ras_n_o;
    p_cas   = cas_n_o;
    p_busy  = busy_o;
    p_ready = ready_o;
  end

  task automatic wait_cas();
    int n0 = n_cas;
    wait (n_cas != n0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R2: request held through initialization must be ignored
    self_ref_req_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(ras_n_o && cas_n_o && we_n_o, "R1", int'({ras_n_o, cas_n_o, we_n_o}), 7);
    chk(!ready_o, "R1", int'(ready_o), 0);
    chk(busy_o, "R1", int'(busy_o), 1);
    @(negedge clk_i);
    #1 rst_ni = 1'b1;

    wait (n_cas == NINIT);
    self_ref_req_i = 1'b0;
    wait (ready_o);
    chk(holds == 0, "R2", holds, 0);

    // R6: free-running spacing
    wait_cas();
    for (int i = 0; i < 3; i++) begin
      wait_cas();
      chk(last_space == REF_CYC - LEAD_CYC + 2, "R6", last_space, REF_CYC - LEAD_CYC + 2);
    end

    // R8: deferral under a long access
    for (int i = 0; i < 2; i++) begin
      access_busy_i = 1'b1;
      wait_cas();
      chk(last_space == REF_CYC, "R8", last_space, REF_CYC);
    end
    access_busy_i = 1'b0;
    wait_cas();
    chk(last_space == REF_CYC - LEAD_CYC + 2, "R6", last_space, REF_CYC - LEAD_CYC + 2);

    // R9 R10 R11: long hold
    repeat (10) @(negedge clk_i);
    self_ref_req_i = 1'b1;
    wait_cas();
    wait_cas();
    chk(last_space == CSR_CYC + RAS_CYC + RP_CYC, "R10", last_space, CSR_CYC + RAS_CYC + RP_CYC);
    repeat (SELF_CYC + 100) @(negedge clk_i);
    chk(!ras_n_o && !cas_n_o, "R9", int'({ras_n_o, cas_n_o}), 0);
    self_ref_req_i = 1'b0;
    wait_cas();
    chk(holds == 1, "R9", holds, 1);
    chk(last_hold >= SELF_CYC, "R9", last_hold, SELF_CYC);
    chk(last_pre == RPS_CYC, "R11", last_pre, RPS_CYC);
    chk(last_space <= REF_CYC, "R10", last_space, REF_CYC);

    // R11: short hold takes the normal precharge
    repeat (30) @(negedge clk_i);
    self_ref_req_i = 1'b1;
    wait_cas();
    wait_cas();
    repeat (40) @(negedge clk_i);
    self_ref_req_i = 1'b0;
    wait_cas();
    chk(holds == 2, "R9", holds, 2);
    chk(last_hold >= RAS_CYC && last_hold < SELF_CYC, "R9", last_hold, RAS_CYC);
    chk(last_pre == RP_CYC, "R11", last_pre, RP_CYC);

    // R5: return to periodic refresh
    wait_cas();
    wait_cas();
    chk(last_space == REF_CYC - LEAD_CYC + 2, "R5", last_space, REF_CYC - LEAD_CYC + 2);
    repeat (5) @(negedge clk_i);
    finish_run();
  end

endmodule